// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block computes even parity over a 32-bit multiplexed address/data bus and the 4-bit command/byte-enable bus of a PCI-style bus. It tracks the bus itself from the cycle-frame, initiator-ready and target-ready strobes. It returns parity one clock behind read data. It also compares the parity the initiator supplies for the address and for write data against a recomputed value.

The block sits beside a bus target. It watches the shared bus lines every clock. On reads it drives the parity line through an output enable that an external tri-state buffer uses. On writes it reports a mismatch as a single-cycle error flag. The transfer direction is taken at the address phase. The block does not implement target or initiator sequencing, error signalling policy, or wide-bus extensions.

Top module: `pci_parity_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `par_oe_o`, `par_o` and `perr_o` are all low.
- R2: The parity bit is even parity over the 36 bits `{ad_i, cbe_n_i}`. It is 1 exactly when those bits hold an odd number of ones.
- R3: An address phase is a clock edge where `frame_n_i` is low while the bus is idle. `par_i` is sampled at the next edge and compared with the parity of the address and command. `perr_o` is high for the one cycle after that edge on a mismatch and stays low on a match.
- R4: In a read data phase, each edge that samples `trdy_n_i` low makes `par_oe_o` high for the following cycle. `par_o` then carries the parity of the bus values sampled at that edge.
- R5: `par_oe_o` is low after any edge that is not a read data phase edge with `trdy_n_i` low. This covers writes, address phases, target wait states and idle. `par_o` is low whenever `par_oe_o` is low.
- R6: A write data transfer is an edge in a write data phase with both `irdy_n_i` and `trdy_n_i` low. `par_i` is sampled at the next edge and compared with the parity of the transferred data and byte enables. `perr_o` pulses for one cycle after that edge on a mismatch only.
- R7: Read data transfers never cause a parity check. `perr_o` stays low after them whatever `par_i` carries.
- R8: `rd_dir_i` (1 = read) is captured at the address phase and ignored later in the transaction. A transfer with `frame_n_i` high ends the transaction, and the next `frame_n_i` low starts a new address phase.
- R9: `perr_o` stays low on idle cycles whatever `par_i` carries.
- R10: A write edge with `irdy_n_i` low and `trdy_n_i` high is a wait state. It arms no check, so `par_i` at the edge after it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Address/data bus as seen on the lines |
| cbe_n_i | input | 4 | Command / byte-enable bus (active low) |
| frame_n_i | input | 1 | Cycle frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| rd_dir_i | input | 1 | Transfer direction at address phase, 1 = read |
| par_i | input | 1 | Parity received from the bus |
| par_o | output | 1 | Parity to drive on read data |
| par_oe_o | output | 1 | Enable for the parity line driver |
| perr_o | output | 1 | One-cycle parity mismatch flag |

## Verification
The assertions assume the bus follows the protocol. A transaction starts only from idle. `frame_n_i` rises only together with a completing transfer. `irdy_n_i` stays high while the bus is idle. The stimulus is built from whole write and read transactions that obey these rules. Each transaction ends with idle cycles, and only `par_i`, `rd_dir_i` inside a transaction and the data on wait-state cycles are varied freely. The sweeps walk a single one across all 36 parity bits and then run multi-beat bursts with and without wait states and with injected parity faults.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_DATA = 1'b1
  } bus_state_e;

  localparam int LANE_W = 8;

endpackage

// File: rtl/pci_par_calc.sv
module pci_par_calc #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  output logic             par_o
);
  import pci_par_pkg::*;

  localparam int LANES = AD_W / LANE_W;
  localparam int REM_W = AD_W - LANES * LANE_W;

  logic [LANES-1:0] lane_par;
  logic             rem_par;

  // one parity bit per byte lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_par[l] = ^ad_i[l*LANE_W +: LANE_W];
  end

  // leftover bits when the bus is not a whole number of lanes
  if (REM_W > 0) begin : g_rem
    assign rem_par = ^ad_i[AD_W-1 -: REM_W];
  end else begin : g_norem
    assign rem_par = 1'b0;
  end

  assign par_o = (^lane_par) ^ rem_par ^ (^cbe_n_i);

endmodule

// File: rtl/pci_phase_track.sv
module pci_phase_track (
  input  logic clk,
  input  logic rst,
  input  logic frame_n_i,
  input  logic irdy_n_i,
  input  logic trdy_n_i,
  input  logic rd_dir_i,
  output logic addr_ph_o,
  output logic data_ph_o,
  output logic rd_lat_o,
  output logic xfer_o
);
  import pci_par_pkg::*;

  bus_state_e state_q;
  logic       rd_q;

  assign addr_ph_o = (state_q == BUS_IDLE) && !frame_n_i;
  assign data_ph_o = (state_q == BUS_DATA);
  assign xfer_o    = data_ph_o && !irdy_n_i && !trdy_n_i;
  assign rd_lat_o  = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      rd_q    <= 1'b0;
    end else begin
      case (state_q)
        BUS_IDLE: begin
          if (!frame_n_i) begin
            state_q <= BUS_DATA;
            rd_q    <= rd_dir_i;
          end
        end
        BUS_DATA: begin
          if (xfer_o && frame_n_i) state_q <= BUS_IDLE;
        end
        default: state_q <= BUS_IDLE;
      endcase
    end
  end

  // R8: a completing transfer with frame high returns the bus to idle
  a_r8_end_of_txn: assert property (@(posedge clk) disable iff (rst)
    (data_ph_o && frame_n_i && !irdy_n_i && !trdy_n_i) |=> !data_ph_o);

endmodule

// File: rtl/pci_par_drive.sv
module pci_par_drive (
  input  logic clk,
  input  logic rst,
  input  logic par_calc_i,
  input  logic data_ph_i,
  input  logic rd_lat_i,
  input  logic trdy_n_i,
  output logic par_o,
  output logic par_oe_o
);

  logic drive_now;

  assign drive_now = data_ph_i && rd_lat_i && !trdy_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_oe_o <= 1'b0;
      par_o    <= 1'b0;
    end else begin
      par_oe_o <= drive_now;
      par_o    <= drive_now & par_calc_i;
    end
  end

  // R4: the driver is only enabled after target-ready was seen
  a_r4_oe_after_trdy: assert property (@(posedge clk) disable iff (rst)
    par_oe_o |-> !$past(trdy_n_i));

endmodule

// File: rtl/pci_par_check.sv
module pci_par_check (
  input  logic clk,
  input  logic rst,
  input  logic par_calc_i,
  input  logic arm_i,
  input  logic par_i,
  output logic perr_o
);

  logic pend_q;
  logic exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      perr_o <= 1'b0;
    end else begin
      pend_q <= arm_i;
      exp_q  <= par_calc_i;
      perr_o <= pend_q && (par_i != exp_q);
    end
  end

  // R6: a flag is only raised two edges after a check was armed
  a_r6_flag_needs_arm: assert property (@(posedge clk) disable iff (rst)
    perr_o |-> $past(arm_i, 2));

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             rd_dir_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_o
);

  logic par_calc;
  logic addr_ph;
  logic data_ph;
  logic rd_lat;
  logic xfer;
  logic arm;

  pci_par_calc #(.AD_W(AD_W), .CBE_W(CBE_W)) u_calc (
    .ad_i    (ad_i),
    .cbe_n_i (cbe_n_i),
    .par_o   (par_calc)
  );

  pci_phase_track u_track (
    .clk       (clk),
    .rst       (rst),
    .frame_n_i (frame_n_i),
    .irdy_n_i  (irdy_n_i),
    .trdy_n_i  (trdy_n_i),
    .rd_dir_i  (rd_dir_i),
    .addr_ph_o (addr_ph),
    .data_ph_o (data_ph),
    .rd_lat_o  (rd_lat),
    .xfer_o    (xfer)
  );

  pci_par_drive u_drive (
    .clk        (clk),
    .rst        (rst),
    .par_calc_i (par_calc),
    .data_ph_i  (data_ph),
    .rd_lat_i   (rd_lat),
    .trdy_n_i   (trdy_n_i),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o)
  );

  // checks are armed by an address phase or a completed write transfer
  assign arm = addr_ph || (xfer && !rd_lat);

  pci_par_check u_check (
    .clk        (clk),
    .rst        (rst),
    .par_calc_i (par_calc),
    .arm_i      (arm),
    .par_i      (par_i),
    .perr_o     (perr_o)
  );

  // R1: outputs are clear on the first cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!par_oe_o && !perr_o && !par_o));

  // R2: driven parity is even over the bus values of the previous edge
  a_r2_even_parity: assert property (@(posedge clk) disable iff (rst)
    par_oe_o |-> (par_o == (^{$past(ad_i), $past(cbe_n_i)})));

  // R5: the line is only driven after a read data phase
  a_r5_read_only_drive: assert property (@(posedge clk) disable iff (rst)
    par_oe_o |-> ($past(data_ph) && $past(rd_lat)));

  // R7: a read transfer never leads to an error flag
  a_r7_no_read_check: assert property (@(posedge clk) disable iff (rst)
    perr_o |-> !($past(xfer, 2) && $past(rd_lat, 2)));

  // R9: an error needs frame or initiator-ready activity two edges earlier
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    perr_o |-> (!$past(frame_n_i, 2) || !$past(irdy_n_i, 2)));

endmodule

// File: tb/pci_parity_unit_test.sv
module pci_parity_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic        rd_dir = 1'b0;
  logic        par_in = 1'b0;
  logic        par_out;
  logic        par_oe;
  logic        perr;

  int  n_checks = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pci_parity_unit uut (
    .clk       (clk),
    .rst       (rst),
    .ad_i      (ad),
    .cbe_n_i   (cbe_n),
    .frame_n_i (frame_n),
    .irdy_n_i  (irdy_n),
    .trdy_n_i  (trdy_n),
    .rd_dir_i  (rd_dir),
    .par_i     (par_in),
    .par_o     (par_out),
    .par_oe_o  (par_oe),
    .perr_o    (perr)
  );

  // even parity bit from a population count
  function automatic logic epar(input logic [31:0] a, input logic [3:0] c);
    return logic'(($countones({a, c}) % 2) == 1);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
  endtask

  // whole write transaction; err bit 0 corrupts address parity, bit k+1 beat k
  task automatic do_write(input logic [31:0] addr, input logic [3:0] cmd,
                          input int beats, input logic [31:0] seed,
                          input logic [3:0] bk0, input logic [7:0] err,
                          input bit waits);
    logic  pend_par;
    logic  pend_err;
    bit    have_pend;
    string pend_tag;
    logic [31:0] dk;
    logic [3:0]  bk;
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
    ad = addr; cbe_n = cmd; rd_dir = 1'b0; par_in = 1'b0;
    tick();
    chk("R5 write address oe", par_oe, 1'b0);
    pend_par = epar(addr, cmd); pend_err = err[0]; have_pend = 1'b1;
    pend_tag = "R3 address check";
    for (int k = 0; k < beats; k++) begin
      dk = seed + 32'(k) * 32'h9E3779B9;
      bk = bk0 + 4'(k);
      if (waits) begin
        frame_n = 1'b0; irdy_n = 1'b0; trdy_n = 1'b1;
        ad = dk; cbe_n = bk; rd_dir = 1'b1;
        par_in = pend_par ^ pend_err;
        tick();
        chk(have_pend ? pend_tag : "R10 wait no check", perr, have_pend ? pend_err : 1'b0);
        chk("R5 write wait oe", par_oe, 1'b0);
        have_pend = 1'b0;
      end
      frame_n = (k == beats - 1); irdy_n = 1'b0; trdy_n = 1'b0;
      ad = dk; cbe_n = bk; rd_dir = 1'b1;  // R8: late direction ignored
      par_in = have_pend ? (pend_par ^ pend_err) : ~epar(dk, bk);
      tick();
      chk(have_pend ? pend_tag : "R10 after wait", perr, have_pend ? pend_err : 1'b0);
      chk("R5 R8 write data oe", par_oe, 1'b0);
      pend_par = epar(dk, bk); pend_err = err[k+1]; have_pend = 1'b1;
      pend_tag = "R6 write data check";
    end
    go_idle();
    ad = ~ad; par_in = pend_par ^ pend_err;
    tick();
    chk(pend_tag, perr, pend_err);
    par_in = ~par_in;
    tick();
    chk("R9 idle after write", perr, 1'b0);
    chk("R5 idle oe", par_oe, 1'b0);
  endtask

  // whole read transaction with address parity fault aerr
  task automatic do_read(input logic [31:0] addr, input logic [3:0] cmd,
                         input int beats, input logic [31:0] seed,
                         input logic [3:0] bk0, input logic aerr,
                         input bit waits);
    logic apar;
    logic prev_par;
    bit   have_pend;
    logic [31:0] dk;
    logic [3:0]  bk;
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
    ad = addr; cbe_n = cmd; rd_dir = 1'b1; par_in = 1'b0;
    tick();
    chk("R5 read address oe", par_oe, 1'b0);
    apar = epar(addr, cmd); have_pend = 1'b1; prev_par = 1'b0;
    for (int k = 0; k < beats; k++) begin
      dk = seed + 32'(k) * 32'h9E3779B9;
      bk = bk0 + 4'(k);
      if (waits) begin
        frame_n = 1'b0; irdy_n = 1'b0; trdy_n = 1'b1;
        ad = ~dk; cbe_n = bk; rd_dir = 1'b0;
        par_in = have_pend ? (apar ^ aerr) : ~prev_par;
        tick();
        chk(have_pend ? "R3 read address check" : "R7 read no check", perr,
            have_pend ? aerr : 1'b0);
        chk("R5 target wait oe", par_oe, 1'b0);
        chk("R5 target wait par", par_out, 1'b0);
        have_pend = 1'b0;
      end
      frame_n = (k == beats - 1); irdy_n = 1'b0; trdy_n = 1'b0;
      ad = dk; cbe_n = bk; rd_dir = 1'b0;  // R8: late direction ignored
      par_in = have_pend ? (apar ^ aerr) : ~prev_par;
      tick();
      chk(have_pend ? "R3 read address check" : "R7 read no check", perr,
          have_pend ? aerr : 1'b0);
      chk("R4 R8 read oe", par_oe, 1'b1);
      chk("R2 R4 read parity", par_out, epar(dk, bk));
      prev_par = epar(dk, bk); have_pend = 1'b0;
    end
    go_idle();
    par_in = ~prev_par;
    tick();
    chk("R7 after last read", perr, 1'b0);
    chk("R5 read end oe", par_oe, 1'b0);
    chk("R5 read end par", par_out, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [35:0] v;
    @(negedge clk);
    rst = 1'b1; par_in = 1'b1; frame_n = 1'b0;
    tick(); tick();
    chk("R1 reset oe", par_oe, 1'b0);
    chk("R1 reset perr", perr, 1'b0);
    chk("R1 reset par", par_out, 1'b0);
    go_idle();
    tick();
    rst = 1'b0;
    tick();
    chk("R1 after reset oe", par_oe, 1'b0);
    chk("R1 after reset perr", perr, 1'b0);
    for (int i = 0; i < 4; i++) begin
      par_in = i[0];
      tick();
      chk("R9 idle perr", perr, 1'b0);
    end

    // walking one over all 36 parity bits
    for (int i = 0; i < 36; i++) begin
      v = 36'h1 << i;
      do_write(v[35:4], v[3:0], 1, ~v[35:4], ~v[3:0], {6'b0, i[1], i[0]}, 1'b0);
      do_read(v[35:4], v[3:0], 1, v[35:4], v[3:0], i[2], 1'b0);
    end

    // multi-beat bursts, wait states and fault injection
    for (int s = 0; s < 16; s++) begin
      do_write(32'(s) * 32'h11111111, 4'h7, 1 + (s % 4), 32'(s) * 32'h01234567,
               4'(s), 8'(s * 91), s[0]);
      do_read(32'(s) * 32'h0F0F0F0F, 4'h6, 1 + ((s + 1) % 4), 32'(s) * 32'h89ABCDEF,
              4'(15 - s), s[1], s[2]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule